// File: doc/BRIEF.md
# Dual-Channel Serial ADC Readout Sequencer

This block is the serial master for a converter that samples two inputs at the same time and returns both 12-bit results in one frame. It drives chip select and the serial clock, samples the data line, and drives three multiplexer address lines. The converter has no control register. Its power state follows from frame length alone: a frame of at least sixteen clocks wakes it, and a frame of exactly eight clocks puts it to sleep.

A one-shot request wakes the converter, runs one conversion and sends it back to sleep. A streaming session wakes the converter once, runs one conversion frame for every trigger, and puts it to sleep when the enable falls. Each conversion returns both raw results and one selected result. The selected result is sign-extended when the configuration makes the data two's complement. Results are held on a valid/ready output until they are taken.

Top module: `dual_adc_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the address is 0, no result is valid, no session is active and one-shot requests are accepted.
- R2: An accepted one-shot request produces three frames in this order: 16 clocks, 32 clocks, 8 clocks. Chip select stays high for at least GAP_LEN = max(CS_GAP, 2*CLK_DIV) cycles before and between frames. The result becomes valid exactly 2*GAP_LEN + 96*CLK_DIV cycles after the accepting edge.
- R3: The 32-clock frame is read most significant bit first. The first 16-bit word is the even result and the second word is the odd result. Each result is bits 13..2 of its word.
- R4: The selected result is the odd result when bit 0 of the latched channel is 1, and the even result when it is 0.
- R5: The selected result is sign-extended from bit 11 to 16 bits when the double-range input is set or the mode is 2 or 3. Otherwise it is zero-extended.
- R6: The address code depends on the mode. Mode 0 (single-ended) gives chan[3:1]. Mode 1 (pseudo-differential) gives chan[2:0] with bit 0 forced to 1. Modes 2 and 3 (differential) give chan[2:0] with bit 0 forced to 0.
- R7: While the fixed-address input is set, requests leave the address outputs unchanged. After reset they stay at 0.
- R8: The address changes only when a request or session is accepted. It is stable while chip select is low.
- R9: Raising the stream enable produces one 16-clock frame. Each trigger accepted afterwards produces one 32-clock frame and one result. Lowering the enable produces one 8-clock frame, after which the session ends.
- R10: While a session is active, the busy output is high and one-shot requests are refused (ready low) and cause no frame.
- R11: A valid result keeps its data stable until it is taken. A trigger that arrives while a frame is running or a result is waiting causes no frame. No new request or session is accepted while a result is waiting.
- R12: The serial clock is low whenever chip select is high. Each of its half periods lasts CLK_DIV cycles, and data is sampled on its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Input mode: 0 single-ended, 1 pseudo-differential, 2/3 differential |
| cfg_range2x | input | 1 | Double-range setting; makes results signed |
| cfg_fixed_addr | input | 1 | Leave the address outputs untouched |
| chan | input | 4 | Requested channel, latched when a request or session is accepted |
| req_valid | input | 1 | One-shot request |
| req_ready | output | 1 | One-shot request accepted when high together with req_valid |
| stream_en | input | 1 | Streaming session enable (level) |
| trig | input | 1 | Conversion trigger inside a session |
| stream_busy | output | 1 | A streaming session is active |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_miso | input | 1 | Serial data from the converter |
| adc_addr | output | 3 | Multiplexer address |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_even | output | 12 | Raw result of the even channel |
| res_odd | output | 12 | Raw result of the odd channel |
| res_sel | output | 16 | Selected result, sign- or zero-extended |

## Verification
With CLK_DIV = 2 and a gap of 6 cycles, a one-shot result is due 204 cycles after the accepting edge. A streaming result is due 128 cycles after the trigger is taken. The bench records the accepting edge and checks the exact one-shot latency when res_valid first rises. For every frame it checks the clock count and the address when chip select returns high, so an extra, missing or misplaced frame fails at that frame. Results are compared at the handshake against the scoreboard queue in order, and outputs are sampled on the falling system clock edge.

// File: rtl/dual_adc_seq.sv
module dual_adc_seq #(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 6,
  parameter int WORD_W  = 16,
  parameter int RES_W   = 12,
  parameter int RES_LSB = 2,
  parameter int SEL_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_range2x,
  input  logic             cfg_fixed_addr,
  input  logic [3:0]       chan,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             stream_en,
  input  logic             trig,
  output logic             stream_busy,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  input  logic             adc_miso,
  output logic [2:0]       adc_addr,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_even,
  output logic [RES_W-1:0] res_odd,
  output logic [SEL_W-1:0] res_sel
);
  localparam int GAP_LEN = (CS_GAP > 2*CLK_DIV) ? CS_GAP : 2*CLK_DIV;
  localparam int GW      = $clog2(GAP_LEN);
  localparam int DW      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int FR_W    = 2*WORD_W;
  localparam int BW      = $clog2(FR_W+1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_FRAME, S_SIDLE} st_t;
  typedef enum logic [1:0] {K_WAKE, K_CONV, K_PDN, K_NONE} kind_t;

  st_t              st;
  kind_t            kind;
  logic [GW-1:0]    gcnt;
  logic [DW-1:0]    dcnt;
  logic [BW-1:0]    bcnt, flen;
  logic [FR_W-1:0]  sh;
  logic [3:0]       chan_q;
  logic             sgn_q;
  logic [2:0]       code;
  logic             start_os, start_st;
  logic [RES_W-1:0] pick;

  always_comb
    case (cfg_mode)
      2'd0:    code = chan[3:1];
      2'd1:    code = chan[2:0] | 3'b001;
      default: code = chan[2:0] & 3'b110;
    endcase

  assign flen      = (kind == K_WAKE) ? BW'(WORD_W) :
                     (kind == K_CONV) ? BW'(FR_W) : BW'(WORD_W/2);
  assign req_ready = (st == S_IDLE) && !stream_en && !res_valid;
  assign start_os  = req_ready && req_valid;
  assign start_st  = (st == S_IDLE) && stream_en && !res_valid;
  assign adc_cs_n  = (st != S_FRAME);
  assign pick      = chan_q[0] ? res_odd : res_even;
  assign res_sel   = sgn_q ? {{(SEL_W-RES_W){pick[RES_W-1]}}, pick}
                           : {{(SEL_W-RES_W){1'b0}}, pick};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_NONE; gcnt <= '0; dcnt <= '0; bcnt <= '0;
      sh <= '0; chan_q <= '0; sgn_q <= 1'b0; adc_addr <= '0; adc_sclk <= 1'b0;
      stream_busy <= 1'b0; res_valid <= 1'b0; res_even <= '0; res_odd <= '0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (start_st || start_os) begin
            chan_q <= chan;
            sgn_q  <= cfg_range2x || cfg_mode[1];
            if (!cfg_fixed_addr) adc_addr <= code;
            stream_busy <= start_st;
            kind <= K_WAKE;
            gcnt <= '0;
            st   <= S_GAP;
          end
        S_GAP:
          if (gcnt == GW'(GAP_LEN-1)) begin
            gcnt <= '0;
            if (kind != K_NONE) st <= S_FRAME;
            else st <= stream_busy ? S_SIDLE : S_IDLE;
          end else gcnt <= gcnt + 1'b1;
        S_SIDLE:
          if (!stream_en) begin
            kind <= K_PDN; st <= S_FRAME;
          end else if (trig && !res_valid) begin
            kind <= K_CONV; st <= S_FRAME;
          end
        default:
          if (dcnt == DW'(CLK_DIV-1)) begin
            dcnt <= '0;
            adc_sclk <= !adc_sclk;
            if (!adc_sclk) begin
              sh   <= {sh[FR_W-2:0], adc_miso};
              bcnt <= bcnt + 1'b1;
            end else if (bcnt == flen) begin
              bcnt <= '0;
              st   <= S_GAP;
              case (kind)
                K_WAKE: kind <= stream_busy ? K_NONE : K_CONV;
                K_CONV: begin
                  res_valid <= 1'b1;
                  res_even  <= RES_W'(sh[FR_W-1:WORD_W] >> RES_LSB);
                  res_odd   <= RES_W'(sh[WORD_W-1:0] >> RES_LSB);
                  kind <= stream_busy ? K_NONE : K_PDN;
                end
                default: begin
                  kind <= K_NONE;
                  stream_busy <= 1'b0;
                end
              endcase
            end
          end else dcnt <= dcnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dual_adc_seq_chk.sv
module dual_adc_seq_chk #(
  parameter int RES_W = 12,
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_fixed_addr,
  input logic             req_ready,
  input logic             stream_busy,
  input logic             adc_cs_n,
  input logic             adc_sclk,
  input logic [2:0]       adc_addr,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_even,
  input logic [RES_W-1:0] res_odd,
  input logic [SEL_W-1:0] res_sel
);
  logic       sclk_q;
  logic [6:0] rises;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; rises <= '0;
    end else begin
      sclk_q <= adc_sclk;
      if (adc_cs_n && !(sclk_q == 1'b0 && adc_sclk)) begin
        if (rises != 0 && $past(adc_cs_n)) rises <= '0;
      end else if (adc_sclk && !sclk_q) rises <= rises + 1'b1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk); // R12
  AST_ADDR_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> $stable(adc_addr)); // R8
  AST_FIXED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fixed_addr |=> $stable(adc_addr)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_even) && $stable(res_odd) && $stable(res_sel)); // R11
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    stream_busy |-> !req_ready); // R10
  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> (rises == 7'd8 || rises == 7'd16 || rises == 7'd32)); // R2
endmodule

bind dual_adc_seq dual_adc_seq_chk #(.RES_W(RES_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fixed_addr(cfg_fixed_addr), .req_ready(req_ready),
  .stream_busy(stream_busy), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
  .adc_addr(adc_addr), .res_valid(res_valid), .res_ready(res_ready),
  .res_even(res_even), .res_odd(res_odd), .res_sel(res_sel)
);

// File: tb/dual_adc_seq_tb.sv
`timescale 1ns/1ps
module dual_adc_seq_tb;
  localparam int CLK_DIV = 2;
  localparam int GAP_LEN = 6;
  localparam int OS_LAT  = 2*GAP_LEN + 96*CLK_DIV;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 0;
  logic cfg_range2x = 0, cfg_fixed_addr = 0;
  logic [3:0] chan = 0;
  logic req_valid = 0, stream_en = 0, trig = 0, res_ready = 1, adc_miso = 0;
  logic req_ready, stream_busy, adc_cs_n, adc_sclk, res_valid;
  logic [2:0] adc_addr;
  logic [11:0] res_even, res_odd;
  logic [15:0] res_sel;

  int nchk = 0, nerr = 0, cyc = 0, t_acc = 0;
  bit os_timing = 0, finished = 0;
  int exp_len[$];
  logic [2:0] exp_addr[$];
  logic [31:0] adc_q[$];
  logic [39:0] exp_res[$];
  logic [2:0] cur_addr = 0;

  always #10 clk = ~clk;

  dual_adc_seq #(.CLK_DIV(CLK_DIV), .CS_GAP(GAP_LEN)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [2:0] addr_of(input logic [1:0] m, input logic [3:0] c);
    case (m)
      2'd0: return c[3:1];
      2'd1: return c[2:0] | 3'b001;
      default: return c[2:0] & 3'b110;
    endcase
  endfunction

  function automatic logic [15:0] word_of(input logic [11:0] v);
    return {2'b10, v, 2'b01};
  endfunction

  function automatic logic [39:0] res_of(input logic [11:0] e, input logic [11:0] o,
                                         input logic [3:0] c, input bit sgn);
    logic [11:0] p;
    p = c[0] ? o : e;
    return {e, o, sgn ? {{4{p[11]}}, p} : {4'b0, p}};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (req_valid && req_ready) t_acc <= cyc + 1;
  end

  // converter model
  logic [31:0] mshift;
  int rises = 0;
  bit in_frame = 0;
  realtime last_rise;
  always @(negedge adc_cs_n) begin
    mshift = (adc_q.size() != 0) ? adc_q[0] : 32'h5A5A_0F0F;
    adc_miso = mshift[31];
    rises = 0;
    in_frame = 1;
  end
  always @(negedge adc_sclk) if (!adc_cs_n) begin
    mshift = mshift << 1;
    adc_miso = mshift[31];
  end
  always @(posedge adc_sclk) if (!adc_cs_n) begin
    if (rises > 0)
      chk($realtime - last_rise == 40.0*CLK_DIV, "R12 sclk period", 40'($rtoi($realtime - last_rise)), 40'(40*CLK_DIV));
    last_rise = $realtime;
    rises++;
  end

  // frame scoreboard
  always @(posedge adc_cs_n) if (in_frame) begin
    in_frame = 0;
    if (exp_len.size() == 0) chk(0, "R2/R9/R10/R11 unexpected frame", 40'(rises), 0);
    else begin
      int e;
      e = exp_len.pop_front();
      chk(rises == e, "R2/R9 frame length", 40'(rises), 40'(e));
      if (e == 32) begin
        logic [2:0] a;
        a = exp_addr.pop_front();
        chk(adc_addr == a, "R6/R7/R8 address at conversion", 40'(adc_addr), 40'(a));
        void'(adc_q.pop_front());
      end
    end
  end

  // result scoreboard
  bit rv_q = 0;
  always @(negedge clk) if (rst_n) begin
    if (res_valid && !rv_q && os_timing) begin
      chk(cyc - t_acc == OS_LAT, "R2 result latency", 40'(cyc - t_acc), 40'(OS_LAT));
      os_timing = 0;
    end
    rv_q = res_valid;
    if (res_valid && res_ready) begin
      if (exp_res.size() == 0) chk(0, "R11 unexpected result", {res_even, res_odd, res_sel}, 0);
      else begin
        logic [39:0] e;
        e = exp_res.pop_front();
        chk(e[39:16] == {res_even, res_odd}, "R3 raw results", {16'b0, res_even, res_odd}, {16'b0, e[39:16]});
        chk(e[15:0] == res_sel, "R4/R5 selected result", 40'(res_sel), 40'(e[15:0]));
      end
    end
  end

  task automatic wait_done();
    while (exp_len.size() != 0 || exp_res.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic oneshot(input logic [1:0] m, input bit r2, input bit fx,
                         input logic [3:0] c, input logic [11:0] e, input logic [11:0] o);
    if (!fx) cur_addr = addr_of(m, c);
    exp_len.push_back(16); exp_len.push_back(32); exp_len.push_back(8);
    exp_addr.push_back(cur_addr);
    adc_q.push_back({word_of(e), word_of(o)});
    exp_res.push_back(res_of(e, o, c, r2 || m[1]));
    @(posedge clk); #1;
    cfg_mode = m; cfg_range2x = r2; cfg_fixed_addr = fx; chan = c; req_valid = 1;
    do @(negedge clk); while (!req_ready);
    os_timing = 1;
    @(posedge clk); #1 req_valid = 0;
    wait_done();
  endtask

  task automatic pulse_trig();
    @(posedge clk); #1 trig = 1;
    @(posedge clk); #1 trig = 0;
  endtask

  task automatic stream_conv(input logic [11:0] e, input logic [11:0] o, input bit sgn);
    exp_len.push_back(32); exp_addr.push_back(cur_addr);
    adc_q.push_back({word_of(e), word_of(o)});
    exp_res.push_back(res_of(e, o, chan, sgn));
    pulse_trig();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(adc_cs_n && !adc_sclk && adc_addr == 0, "R1 reset pins", {adc_cs_n, adc_sclk, adc_addr}, 5'b10000);
    chk(!res_valid && req_ready && !stream_busy, "R1 reset handshake", {res_valid, req_ready, stream_busy}, 3'b010);

    oneshot(2'd0, 0, 1, 4'd5, 12'h123, 12'h9AB);   // R7 fixed: address stays 0
    oneshot(2'd0, 0, 0, 4'd5, 12'h123, 12'h9AB);   // R6 SE, R4 odd, R5 unsigned
    oneshot(2'd1, 0, 0, 4'd4, 12'hF00, 12'h001);   // R6 PD, R5 zero-extend
    oneshot(2'd2, 0, 0, 4'd3, 12'h7FF, 12'h800);   // R6 diff, R5 signed
    oneshot(2'd0, 1, 0, 4'd6, 12'hFFF, 12'h000);   // R5 double range signed
    oneshot(2'd3, 0, 1, 4'd9, 12'hA5A, 12'h5A5);   // R7 held previous address

    // streaming R9
    @(posedge clk); #1;
    cfg_mode = 2'd1; cfg_range2x = 0; cfg_fixed_addr = 0; chan = 4'd2;
    cur_addr = addr_of(2'd1, 4'd2);
    exp_len.push_back(16);
    stream_en = 1;
    wait_done();
    chk(stream_busy === 1'b1, "R9 session active", 40'(stream_busy), 1);
    stream_conv(12'h321, 12'hC0D, 0);
    wait_done();
    // R10 refused one-shot
    @(posedge clk); #1 req_valid = 1;
    repeat (20) begin
      @(negedge clk);
      chk(!req_ready && stream_busy, "R10 refused while busy", {req_ready, stream_busy}, 2'b01);
    end
    @(posedge clk); #1 req_valid = 0;
    repeat (10) @(negedge clk);
    // R11 trigger during frame ignored
    stream_conv(12'h0F0, 12'hF0F, 0);
    repeat (20) @(posedge clk);
    pulse_trig();
    wait_done();
    // R11 trigger while result waiting ignored
    res_ready = 0;
    stream_conv(12'h456, 12'h789, 0);
    while (!res_valid) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(res_valid === 1'b1, "R11 result held", 40'(res_valid), 1);
    pulse_trig();
    repeat (150) @(negedge clk);
    chk(exp_len.size() == 0, "R11 no frame while pending", 40'(exp_len.size()), 0);
    @(posedge clk); #1 res_ready = 1;
    wait_done();
    // R9 disable
    exp_len.push_back(8);
    @(posedge clk); #1 stream_en = 0;
    wait_done();
    chk(!stream_busy && req_ready, "R9 session ended", {stream_busy, req_ready}, 2'b01);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule